// File: doc/BRIEF.md
# Partial Memory-Map Address Decoder

This block turns the 16-bit address bus of an 8-bit processor into three active-low chip enables. One is for work RAM, one is for a bank of eight video-chip registers, and one is for cartridge program ROM. The decode looks only at the three most significant address lines, qualified by the processor's phase-2 clock. Because of that, RAM and the register bank repeat across the whole 8 KiB window that each of them owns.

Decoding takes two stages. The first stage splits the map into a lower half and an upper half using A15 and phase-2. The second stage is enabled by the lower-half select and uses A14 and A13 to pick the RAM window ($0000-$1FFF) or the register window ($2000-$3FFF). The range $4000-$7FFF selects nothing.

The block also routes low address bits to each device:
- 11 bits as the RAM offset.
- 3 bits as the register index.
- 15 bits straight to the ROM, with the upper-half select standing in for a 16th ROM address bit.

A 2 KiB RAM and a stub register file sit behind the decoder so that the mirroring can be observed through the read data.

Top module: `mm_addr_decoder`

## Requirements
- R1: `rom_ce_no` is 0 exactly when `phi2_i` is 1 and A15 is 1, which covers $8000-$FFFF.
- R2: `ram_ce_no` is 0 exactly when `phi2_i` is 1 and A15, A14 and A13 are all 0, which covers $0000-$1FFF.
- R3: `vreg_ce_no` is 0 exactly when `phi2_i` is 1 and A15..A13 equal 3'b001, which covers $2000-$3FFF.
- R4: At most one of the three enables is 0 in any cycle. Addresses $4000-$7FFF leave all three enables at 1.
- R5: While `phi2_i` is 0, all enables are 1 and a write has no effect on RAM or on the registers.
- R6: `rom_addr_o` equals A14..A0 for every address.
- R7: `vreg_idx_o` equals A2..A0. A write anywhere in the register window updates register A2..A0, so a write to $2007 is read back at $3FFF.
- R8: `ram_addr_o` equals A10..A0. The 2 KiB RAM repeats four times in $0000-$1FFF, so a byte written at address a is read back at a+$800, a+$1000 and a+$1800.
- R9: Reset (`rst_ni` = 0) clears all eight registers to 8'h00.
- R10: `rdata_o` is 8'h00 whenever neither the RAM enable nor the register enable is 0. Otherwise it shows the selected RAM byte or register value in the same cycle.
- R11: A write (`we_i` = 1 with `phi2_i` = 1) to the ROM window or to $4000-$7FFF changes neither the RAM nor the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; writes are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | Phase-2 qualifier; the bus cycle is valid while it is 1 |
| we_i | input | 1 | Write strobe from the processor |
| addr_i | input | 16 | Processor address |
| wdata_i | input | 8 | Write data |
| ram_ce_no | output | 1 | Work RAM enable, active low |
| vreg_ce_no | output | 1 | Video register enable, active low |
| rom_ce_no | output | 1 | Program ROM enable, active low |
| ram_addr_o | output | 11 | RAM offset, A10..A0 |
| vreg_idx_o | output | 3 | Register index, A2..A0 |
| rom_addr_o | output | 15 | ROM address, A14..A0 |
| rdata_o | output | 8 | Read data from the RAM or from the register stub |

## Verification
Two things can happen in the same cycle: a write landing on one alias of a storage location, and a read through a different alias of that location. The bench provokes this by writing RAM only through its top mirror and writing registers at random window addresses. It then reads through other mirrors and checks `rdata_o` against a bench model that folds each address by the stated mirroring rule. Mixed into the random traffic are writes with phase-2 low and writes to the ROM and unmapped windows. Each of these is judged by reading back, through the normal read path, the locations it could have disturbed.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;
  parameter int ADDR_W  = 16;
  parameter int DATA_W  = 8;
  parameter int RAM_AW  = 11;
  parameter int VREG_AW = 3;
  parameter int ROM_AW  = ADDR_W - 1;
  parameter int WIN_W   = 2;   // A14..A13 select an 8 KiB window in the lower half

  typedef enum logic [WIN_W-1:0] {
    WIN_RAM  = 2'd0,
    WIN_VREG = 2'd1,
    WIN_OPEN = 2'd2,
    WIN_SPARE = 2'd3
  } win_e;
endpackage

// File: rtl/mm_half_decode.sv
`timescale 1ns/1ps
module mm_half_decode (
  input  logic phi2_i,
  input  logic a_msb_i,
  output logic lo_en_no,
  output logic hi_en_no
);
  always_comb begin
    lo_en_no = ~(phi2_i & ~a_msb_i);
    hi_en_no = ~(phi2_i &  a_msb_i);
  end
endmodule

// File: rtl/mm_window_decode.sv
`timescale 1ns/1ps
module mm_window_decode #(
  parameter int SEL_W   = 2,
  parameter int NUM_OUT = 2
) (
  input  logic               en_ni,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_OUT-1:0] ce_no
);
  // only the first NUM_OUT window codes drive an enable; the rest decode to nothing
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign ce_no[g] = en_ni | (sel_i != SEL_W'(g));
  end
endmodule

// File: rtl/mm_mirror_ram.sv
`timescale 1ns/1ps
module mm_mirror_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mm_vreg_stub.sv
`timescale 1ns/1ps
module mm_vreg_stub #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           reg_q[g] <= '0;
      else if (we_i && idx_i == AW'(g))      reg_q[g] <= wdata_i;
    end
  end

  assign rdata_o = reg_q[idx_i];
endmodule

// File: rtl/mm_addr_decoder.sv
`timescale 1ns/1ps
module mm_addr_decoder
  import mm_pkg::*;
#(
  parameter int AW  = mm_pkg::ADDR_W,
  parameter int DW  = mm_pkg::DATA_W,
  parameter int RAW = mm_pkg::RAM_AW,
  parameter int VAW = mm_pkg::VREG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phi2_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ram_ce_no,
  output logic          vreg_ce_no,
  output logic          rom_ce_no,
  output logic [RAW-1:0] ram_addr_o,
  output logic [VAW-1:0] vreg_idx_o,
  output logic [AW-2:0] rom_addr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int MSB = AW - 1;
  localparam int NWIN_USED = 2;

  logic                 lo_en_n;
  logic [NWIN_USED-1:0] win_ce_n;
  logic                 ram_we, vreg_we;
  logic [DW-1:0]        ram_rd, vreg_rd;

  mm_half_decode u_half (
    .phi2_i   (phi2_i),
    .a_msb_i  (addr_i[MSB]),
    .lo_en_no (lo_en_n),
    .hi_en_no (rom_ce_no)
  );

  mm_window_decode #(.SEL_W(WIN_W), .NUM_OUT(NWIN_USED)) u_win (
    .en_ni (lo_en_n),
    .sel_i (addr_i[MSB-1 -: WIN_W]),
    .ce_no (win_ce_n)
  );

  assign ram_ce_no  = win_ce_n[WIN_RAM];
  assign vreg_ce_no = win_ce_n[WIN_VREG];

  assign ram_addr_o = addr_i[RAW-1:0];
  assign vreg_idx_o = addr_i[VAW-1:0];
  assign rom_addr_o = addr_i[AW-2:0];

  assign ram_we  = we_i & ~ram_ce_no;
  assign vreg_we = we_i & ~vreg_ce_no;

  mm_mirror_ram #(.AW(RAW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (ram_addr_o),
    .wdata_i (wdata_i),
    .rdata_o (ram_rd)
  );

  mm_vreg_stub #(.AW(VAW), .DW(DW)) u_vreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vreg_we),
    .idx_i   (vreg_idx_o),
    .wdata_i (wdata_i),
    .rdata_o (vreg_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (!ram_ce_no)       rdata_o = ram_rd;
    else if (!vreg_ce_no) rdata_o = vreg_rd;
  end
endmodule

module mm_addr_decoder_chk #(
  parameter int DW  = 8,
  parameter int VAW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           phi2_i,
  input logic           we_i,
  input logic [2:0]     addr_hi_i,
  input logic [DW-1:0]  wdata_i,
  input logic           ram_ce_no,
  input logic           vreg_ce_no,
  input logic           rom_ce_no,
  input logic [VAW-1:0] vreg_idx_o,
  input logic [DW-1:0]  rdata_o
);
  // R4
  one_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~ram_ce_no, ~vreg_ce_no, ~rom_ce_no}) <= 1);

  // R5
  phi2_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phi2_i |-> (ram_ce_no && vreg_ce_no && rom_ce_no));

  // R1
  rom_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2_i && addr_hi_i[2]) |-> (!rom_ce_no && ram_ce_no && vreg_ce_no));

  // R4
  open_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_i[2:1] == 2'b01) |-> (ram_ce_no && vreg_ce_no && rom_ce_no));

  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_ce_no && vreg_ce_no) |-> (rdata_o == '0));

  // R7
  vreg_wr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phi2_i && we_i && !vreg_ce_no) && !vreg_ce_no &&
     vreg_idx_o == $past(vreg_idx_o)) |-> (rdata_o == $past(wdata_i)));
endmodule

bind mm_addr_decoder mm_addr_decoder_chk #(.DW(DW), .VAW(VAW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phi2_i     (phi2_i),
  .we_i       (we_i),
  .addr_hi_i  (addr_i[AW-1 -: 3]),
  .wdata_i    (wdata_i),
  .ram_ce_no  (ram_ce_no),
  .vreg_ce_no (vreg_ce_no),
  .rom_ce_no  (rom_ce_no),
  .vreg_idx_o (vreg_idx_o),
  .rdata_o    (rdata_o)
);

// File: tb/tb_mm_addr_decoder.sv
`timescale 1ns/1ps
module tb_mm_addr_decoder;
  localparam real CLK_PERIOD = 8.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phi2_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ram_ce_no, vreg_ce_no, rom_ce_no;
  logic [10:0] ram_addr_o;
  logic [2:0]  vreg_idx_o;
  logic [14:0] rom_addr_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] ram_m [2048];
  logic [7:0] reg_m [8];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mm_addr_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .phi2_i(phi2_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .ram_ce_no(ram_ce_no), .vreg_ce_no(vreg_ce_no), .rom_ce_no(rom_ce_no),
    .ram_addr_o(ram_addr_o), .vreg_idx_o(vreg_idx_o), .rom_addr_o(rom_addr_o),
    .rdata_o(rdata_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h addr=%04h phi2=%0b", req, act, exp, addr_i, phi2_i);
    end
  endtask

  // returns {rom, vreg, ram} active-low
  function automatic logic [2:0] exp_ce(input logic [15:0] a, input logic p);
    logic [2:0] r;
    r = 3'b111;
    if (p) begin
      if (a[15])                r[2] = 1'b0;
      else if (a[14:13] == 2'b00) r[0] = 1'b0;
      else if (a[14:13] == 2'b01) r[1] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic p);
    if (!p) return 8'h00;
    if (a[15:13] == 3'b000) return ram_m[a[10:0]];
    if (a[15:13] == 3'b001) return reg_m[a[2:0]];
    return 8'h00;
  endfunction

  // drive at falling edge, settle, write taken at next rising edge
  task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d, input logic p);
    @(negedge clk_i);
    addr_i = a; we_i = w; wdata_i = d; phi2_i = p;
    #2;
  endtask

  task automatic model_write(input logic [15:0] a, input logic w, input logic [7:0] d, input logic p);
    if (p && w) begin
      if (a[15:13] == 3'b000)      ram_m[a[10:0]] = d;
      else if (a[15:13] == 3'b001) reg_m[a[2:0]] = d;
    end
  endtask

  task automatic check_decode();
    logic [2:0] e;
    e = exp_ce(addr_i, phi2_i);
    chk("R1", rom_ce_no, e[2]);
    chk("R2", ram_ce_no, e[0]);
    chk("R3", vreg_ce_no, e[1]);
    chk("R4", $countones(~{rom_ce_no, vreg_ce_no, ram_ce_no}) <= 1, 1);
    chk("R6", rom_addr_o, addr_i[14:0]);
    chk("R8", ram_addr_o, addr_i[10:0]);
    chk("R7", vreg_idx_o, addr_i[2:0]);
  endtask

  task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d,
                        input logic p, input string req);
    drive(a, w, d, p);
    chk(req, rdata_o, exp_rd(a, p));
    model_write(a, w, d, p);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    for (int i = 0; i < 8; i++) reg_m[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9: registers read zero after reset, through two mirrors
    for (int i = 0; i < 8; i++) begin
      access(16'h2000 | 16'(i), 1'b0, 8'h00, 1'b1, "R9");
      access(16'h3FF8 | 16'(i), 1'b0, 8'h00, 1'b1, "R9");
    end

    // R8: fill RAM through its top mirror, read back via the other three
    for (int i = 0; i < 2048; i++)
      access(16'h1800 | 16'(i), 1'b1, 8'(i * 7) ^ 8'h3C, 1'b1, "R8");
    for (int i = 0; i < 2048; i += 29) begin
      access(16'(i),           1'b0, 8'h00, 1'b1, "R8");
      access(16'h0800 | 16'(i), 1'b0, 8'h00, 1'b1, "R8");
      access(16'h1000 | 16'(i), 1'b0, 8'h00, 1'b1, "R8");
    end

    // R7: write $2007, read $3FFF and vice versa
    access(16'h2007, 1'b1, 8'hA5, 1'b1, "R7");
    access(16'h3FFF, 1'b0, 8'h00, 1'b1, "R7");
    chk("R7", rdata_o, 8'hA5);
    access(16'h3FF9, 1'b1, 8'h5A, 1'b1, "R7");
    access(16'h2001, 1'b0, 8'h00, 1'b1, "R7");
    chk("R7", rdata_o, 8'h5A);

    // R5: writes with phi2 low are dropped
    access(16'h2003, 1'b1, 8'hFF, 1'b0, "R5");
    chk("R5", {rom_ce_no, vreg_ce_no, ram_ce_no}, 3'b111);
    access(16'h0040, 1'b1, 8'hEE, 1'b0, "R5");
    access(16'h2003, 1'b0, 8'h00, 1'b1, "R5");
    chk("R5", rdata_o, 8'h00);
    access(16'h0040, 1'b0, 8'h00, 1'b1, "R5");
    chk("R5", rdata_o, 8'(16'h40 * 7) ^ 8'h3C);

    // R11 / R10: writes to unmapped and ROM windows leave storage untouched
    access(16'h4003, 1'b1, 8'h77, 1'b1, "R10");
    access(16'h6040, 1'b1, 8'h66, 1'b1, "R10");
    access(16'h8040, 1'b1, 8'h55, 1'b1, "R10");
    access(16'hE003, 1'b1, 8'h44, 1'b1, "R10");
    access(16'h2003, 1'b0, 8'h00, 1'b1, "R11");
    chk("R11", rdata_o, 8'h00);
    access(16'h0040, 1'b0, 8'h00, 1'b1, "R11");
    chk("R11", rdata_o, 8'(16'h40 * 7) ^ 8'h3C);

    // R1-R4, R6-R8: full sweep of the map with phi2 high
    for (int a = 0; a < 65536; a++) begin
      drive(16'(a), 1'b0, 8'h00, 1'b1);
      check_decode();
      if (a >= 16'h4000 && a < 16'h8000)
        chk("R4", {rom_ce_no, vreg_ce_no, ram_ce_no}, 3'b111);
    end

    // R5: sampled sweep with phi2 low
    for (int a = 0; a < 65536; a += 97) begin
      drive(16'(a), 1'b0, 8'h00, 1'b0);
      check_decode();
      chk("R10", rdata_o, 8'h00);
    end

    // constrained random traffic across all windows, aliases mixed
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic        w, p;
      logic [7:0]  d;
      a = 16'($urandom);
      if ($urandom_range(0, 3) != 0) a[15:14] = 2'b00;
      w = 1'($urandom);
      p = ($urandom_range(0, 7) != 0);
      d = 8'($urandom);
      drive(a, w, d, p);
      check_decode();
      chk("R10", rdata_o, exp_rd(a, p));
      model_write(a, w, d, p);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule